// File: doc/BRIEF.md
# Programmable Parallel Peripheral Interface

This block connects a host processor to three 8-bit parallel ports, called A, B and C. The host reaches it over an 8-bit data bus that the block drives only while a read is in progress. Chip select, read strobe and write strobe are all active low, and a two-bit address picks port A, B or C, or the configuration register at address 3. A configuration word written to that register sets the direction of each port. It can also switch ports A and B into a strobed-input handshake, in which four port C lines act as strobe and input-buffer-full signals.

The whole block runs in one clock domain. The host strobes and the peripheral strobes each pass through a two-flop synchroniser and are then edge-detected. Host writes take effect on the trailing edge of the write strobe. A strobed port captures the peripheral's byte on the rising edge of its active-low strobe.

Top module: `ppi_core`

## Requirements
- R1: After reset every port line is an input: all of `pa_oe_o`, `pb_oe_o` and `pc_oe_o` are 0, every output latch and flag is 0, and `data_oe_o` is 0.
- R2: A word written to address 3 with bit 7 = 1 sets the port directions. A 1 in a direction bit means input. The direction bits are: bit 4 for port A, bit 1 for port B, bit 3 for port C lines 7..4, and bit 0 for port C lines 3..0. An output port drives its latch on its pins, with every output enable set.
- R3: Every accepted configuration word clears all three output latches, both input-buffer-full flags, both overrun flags and both captured bytes. This happens even when the word is identical to the current one.
- R4: A write to address 3 with bit 7 = 0 changes nothing: pins, output enables and latches keep their values.
- R5: A host read of port A (address 0) or port B (address 1) returns the pins when the port is an input. It returns the output latch when the port is an output.
- R6: A host read of port C (address 2) takes each nibble from the pins or from the latch according to that nibble's direction bit.
- R7: Strobed input is selected by bits 6..5 = 01 for port A and by bit 2 = 1 for port B. In this mode the port is forced to input. C4 (A) and C2 (B) become strobe inputs, and C5 (A) and C1 (B) become driven input-buffer-full outputs. A rising edge on the strobe captures the port pins and sets input-buffer-full.
- R8: A host read of a strobed port returns the captured byte. Its input-buffer-full flag clears on the trailing edge of that read.
- R9: In strobed mode, a host read of port C returns input-buffer-full of A in bit 5 and of B in bit 1, in place of the pin values.
- R10: A strobe edge while input-buffer-full is set still captures the new byte. It also sets that port's sticky overrun output (`ovr_a_o`, `ovr_b_o`), which stays set until the next configuration word.
- R11: If a port's strobe is low when the port enters strobed mode, the first rising strobe edge captures nothing. Transfers start only after the strobe has been seen high following configuration.
- R12: `data_oe_o` is high only while a host read with chip select is in progress, and never during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Host read strobe, active low |
| wr_ni | input | 1 | Host write strobe, active low |
| addr_i | input | 2 | Port / configuration select |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| data_oe_o | output | 1 | Host bus drive enable |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A pins out |
| pa_oe_o | output | 8 | Port A drive enables |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B pins out |
| pb_oe_o | output | 8 | Port B drive enables |
| pc_i | input | 8 | Port C pins in (strobes on C4, C2) |
| pc_o | output | 8 | Port C pins out (buffer-full on C5, C1) |
| pc_oe_o | output | 8 | Port C drive enables |
| ovr_a_o | output | 1 | Port A overrun, sticky |
| ovr_b_o | output | 1 | Port B overrun, sticky |

## Verification
Random direction words combined with random latch and pin values tell apart a read that should return the pins from one that should return the latch, for each port and each port C nibble. Directed strobe sequences check the handshake itself:
- one strobe followed by a read shows capture and buffer-full clearing;
- two strobes with no read in between show that the second byte is kept and that overrun is flagged;
- a strobe held low across configuration shows the lock-up rule.

Writing the same configuration word twice shows that the reset of the ports does not depend on whether the mode changed.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] SEL_A    = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_B    = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_C    = 2'd2;
  localparam logic [ADDR_W-1:0] SEL_CTRL = 2'd3;

  // configuration word bit positions
  localparam int unsigned CW_DEFINE = 7;
  localparam int unsigned CW_A_DIR  = 4;
  localparam int unsigned CW_CU_DIR = 3;
  localparam int unsigned CW_B_MODE = 2;
  localparam int unsigned CW_B_DIR  = 1;
  localparam int unsigned CW_CL_DIR = 0;

  // handshake lines on port C
  localparam int unsigned HS_STB_A = 4;
  localparam int unsigned HS_IBF_A = 5;
  localparam int unsigned HS_STB_B = 2;
  localparam int unsigned HS_IBF_B = 1;

  localparam int unsigned HALF_W = PORT_W / 2;

  typedef struct packed {
    logic a_strobed;
    logic a_in;
    logic cu_in;
    logic b_strobed;
    logic b_in;
    logic cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{a_strobed: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                 b_strobed: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic cfg_t decode_cw(input logic [PORT_W-1:0] w);
    cfg_t c;
    c.a_strobed = (w[6:5] == 2'b01);
    c.a_in      = w[CW_A_DIR];
    c.cu_in     = w[CW_CU_DIR];
    c.b_strobed = w[CW_B_MODE];
    c.b_in      = w[CW_B_DIR];
    c.cl_in     = w[CW_CL_DIR];
    return c;
  endfunction
endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ppi_host_if.sv
module ppi_host_if (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_ni,
  input  logic rd_s_ni,
  input  logic wr_s_ni,
  output logic wr_done_o,
  output logic rd_done_o,
  output logic rd_act_o
);
  logic wr_prev_q, rd_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_prev_q <= 1'b1;
      rd_prev_q <= 1'b1;
    end else begin
      wr_prev_q <= wr_s_ni;
      rd_prev_q <= rd_s_ni;
    end
  end

  // trailing (rising) edges of the strobes, qualified by chip select
  assign wr_done_o = !cs_s_ni && wr_s_ni && !wr_prev_q;
  assign rd_done_o = !cs_s_ni && rd_s_ni && !rd_prev_q;
  assign rd_act_o  = !cs_s_ni && !rd_s_ni;
endmodule

// File: rtl/ppi_strobe_port.sv
module ppi_strobe_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         cfg_wr_i,
  input  logic         stb_s_ni,
  input  logic [W-1:0] pin_i,
  input  logic         rd_done_i,
  output logic [W-1:0] cap_o,
  output logic         ibf_o,
  output logic         ovr_o,
  output logic         armed_o
);
  logic stb_prev_q;
  logic stb_rise;

  assign stb_rise = stb_s_ni && !stb_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_prev_q <= 1'b1;
      armed_o    <= 1'b0;
      ibf_o      <= 1'b0;
      ovr_o      <= 1'b0;
      cap_o      <= '0;
    end else begin
      stb_prev_q <= stb_s_ni;
      if (cfg_wr_i) begin
        armed_o <= 1'b0;
        ibf_o   <= 1'b0;
        ovr_o   <= 1'b0;
        cap_o   <= '0;
      end else begin
        // strobe must be seen high after configuration before any transfer
        if (en_i && stb_s_ni) armed_o <= 1'b1;
        if (en_i && armed_o && stb_rise) begin
          cap_o <= pin_i;
          ibf_o <= 1'b1;
          if (ibf_o) ovr_o <= 1'b1;
        end else if (rd_done_i) begin
          ibf_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ppi_core.sv
module ppi_core
  import ppi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [PORT_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic [PORT_W-1:0] pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic [PORT_W-1:0] pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [PORT_W-1:0] pc_oe_o,
  output logic              ovr_a_o,
  output logic              ovr_b_o
);
  localparam int unsigned BUS_W = 3 + ADDR_W;
  localparam int unsigned NSTB  = 2;

  logic [BUS_W-1:0]  bus_s;
  logic              cs_s_n, rd_s_n, wr_s_n;
  logic [ADDR_W-1:0] addr_s;
  logic [NSTB-1:0]   stb_s_n;
  logic              wr_done, rd_done, rd_act;

  cfg_t              cfg_q;
  logic              cfg_wr;
  logic              a_strobed, b_strobed;
  logic [PORT_W-1:0] pa_lat_q, pb_lat_q, pc_lat_q;

  logic [NSTB-1:0]             st_en, st_rd, st_ibf, st_ovr, st_armed;
  logic [NSTB-1:0][PORT_W-1:0] st_pin, st_cap;
  logic              ibf_a, ibf_b, armed_a, armed_b;
  logic [PORT_W-1:0] pc_view;

  ppi_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({3'b111, {ADDR_W{1'b0}}})) u_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, rd_ni, wr_ni, addr_i}),
    .q_o   (bus_s)
  );
  assign {cs_s_n, rd_s_n, wr_s_n, addr_s} = bus_s;

  ppi_sync #(.W(NSTB), .STAGES(SYNC_STAGES), .RST_VAL({NSTB{1'b1}})) u_stb_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pc_i[HS_STB_B], pc_i[HS_STB_A]}),
    .q_o   (stb_s_n)
  );

  ppi_host_if u_host (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_s_ni  (cs_s_n),
    .rd_s_ni  (rd_s_n),
    .wr_s_ni  (wr_s_n),
    .wr_done_o(wr_done),
    .rd_done_o(rd_done),
    .rd_act_o (rd_act)
  );

  assign cfg_wr = wr_done && (addr_s == SEL_CTRL) && data_i[CW_DEFINE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= CFG_RESET;
      pa_lat_q <= '0;
      pb_lat_q <= '0;
      pc_lat_q <= '0;
    end else if (cfg_wr) begin
      cfg_q    <= decode_cw(data_i);
      pa_lat_q <= '0;
      pb_lat_q <= '0;
      pc_lat_q <= '0;
    end else if (wr_done) begin
      unique case (addr_s)
        SEL_A:   pa_lat_q <= data_i;
        SEL_B:   pb_lat_q <= data_i;
        SEL_C:   pc_lat_q <= data_i;
        default: ;
      endcase
    end
  end

  assign a_strobed = cfg_q.a_strobed;
  assign b_strobed = cfg_q.b_strobed;

  assign st_en  = {b_strobed, a_strobed};
  assign st_rd  = {rd_done && (addr_s == SEL_B), rd_done && (addr_s == SEL_A)};
  assign st_pin = {pb_i, pa_i};

  for (genvar i = 0; i < NSTB; i++) begin : g_stb
    ppi_strobe_port #(.W(PORT_W)) u_stb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (st_en[i]),
      .cfg_wr_i (cfg_wr),
      .stb_s_ni (stb_s_n[i]),
      .pin_i    (st_pin[i]),
      .rd_done_i(st_rd[i]),
      .cap_o    (st_cap[i]),
      .ibf_o    (st_ibf[i]),
      .ovr_o    (st_ovr[i]),
      .armed_o  (st_armed[i])
    );
  end

  assign ibf_a   = st_ibf[0];
  assign ibf_b   = st_ibf[1];
  assign armed_a = st_armed[0];
  assign armed_b = st_armed[1];
  assign ovr_a_o = st_ovr[0];
  assign ovr_b_o = st_ovr[1];

  // port pins
  assign pa_o    = pa_lat_q;
  assign pb_o    = pb_lat_q;
  assign pa_oe_o = {PORT_W{!(cfg_q.a_in || a_strobed)}};
  assign pb_oe_o = {PORT_W{!(cfg_q.b_in || b_strobed)}};

  always_comb begin
    pc_o    = pc_lat_q;
    pc_oe_o = {{HALF_W{!cfg_q.cu_in}}, {HALF_W{!cfg_q.cl_in}}};
    if (a_strobed) begin
      pc_o[HS_IBF_A]    = ibf_a;
      pc_oe_o[HS_IBF_A] = 1'b1;
      pc_oe_o[HS_STB_A] = 1'b0;
    end
    if (b_strobed) begin
      pc_o[HS_IBF_B]    = ibf_b;
      pc_oe_o[HS_IBF_B] = 1'b1;
      pc_oe_o[HS_STB_B] = 1'b0;
    end
  end

  // host read path
  always_comb begin
    pc_view = {cfg_q.cu_in ? pc_i[PORT_W-1:HALF_W] : pc_lat_q[PORT_W-1:HALF_W],
               cfg_q.cl_in ? pc_i[HALF_W-1:0]      : pc_lat_q[HALF_W-1:0]};
    if (a_strobed) begin
      pc_view[HS_IBF_A] = ibf_a;
      pc_view[HS_STB_A] = pc_i[HS_STB_A];
    end
    if (b_strobed) begin
      pc_view[HS_IBF_B] = ibf_b;
      pc_view[HS_STB_B] = pc_i[HS_STB_B];
    end
  end

  always_comb begin
    unique case (addr_s)
      SEL_A:   data_o = a_strobed ? st_cap[0] : (cfg_q.a_in ? pa_i : pa_lat_q);
      SEL_B:   data_o = b_strobed ? st_cap[1] : (cfg_q.b_in ? pb_i : pb_lat_q);
      SEL_C:   data_o = pc_view;
      default: data_o = '0;
    endcase
  end

  assign data_oe_o = rd_act;
endmodule

// File: rtl/ppi_checker.sv
module ppi_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_wr,
  input logic       a_strobed,
  input logic       b_strobed,
  input logic       ibf_a,
  input logic       ibf_b,
  input logic       armed_a,
  input logic       armed_b,
  input logic       ovr_a,
  input logic       ovr_b,
  input logic [7:0] pa_o,
  input logic [7:0] pb_o,
  input logic [7:0] pc_o,
  input logic [7:0] pc_oe_o
);
  a_r3_cfg_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr |=> (pa_o == 8'h00 && pb_o == 8'h00 && pc_o == 8'h00 &&
                !ibf_a && !ibf_b && !ovr_a && !ovr_b));

  a_r7_hs_dir_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_strobed |-> (pc_oe_o[5] && !pc_oe_o[4]));

  a_r7_hs_dir_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_strobed |-> (pc_oe_o[1] && !pc_oe_o[2]));

  a_r10_ovr_a_after_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_a) |-> $past(ibf_a));

  a_r10_ovr_b_after_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_b) |-> $past(ibf_b));

  a_r11_armed_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ibf_a) |-> $past(armed_a));

  a_r11_armed_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ibf_b) |-> $past(armed_b));
endmodule

bind ppi_core ppi_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_wr   (cfg_wr),
  .a_strobed(a_strobed),
  .b_strobed(b_strobed),
  .ibf_a    (ibf_a),
  .ibf_b    (ibf_b),
  .armed_a  (armed_a),
  .armed_b  (armed_b),
  .ovr_a    (ovr_a_o),
  .ovr_b    (ovr_b_o),
  .pa_o     (pa_o),
  .pb_o     (pb_o),
  .pc_o     (pc_o),
  .pc_oe_o  (pc_oe_o)
);

// File: tb/tb_ppi_core.sv
`timescale 1ns/1ps
module tb_ppi_core;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic       data_oe_o;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = 8'hFF;
  logic [7:0] pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;
  logic       ovr_a_o, ovr_b_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_cw, m_pa, m_pb, m_pc;
  logic [7:0] rv;
  logic       oe_seen;

  always #5 clk = ~clk;

  ppi_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe_o),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe_o),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe_o),
    .ovr_a_o(ovr_a_o), .ovr_b_o(ovr_b_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_ni = 1'b0; addr_i = a; data_i = d;
    @(negedge clk);
    wr_ni = 1'b0;
    repeat (4) @(negedge clk);
    oe_seen = data_oe_o;
    wr_ni = 1'b1;
    repeat (5) @(negedge clk);
    cs_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_ni = 1'b0; addr_i = a;
    @(negedge clk);
    rd_ni = 1'b0;
    repeat (5) @(negedge clk);
    d = data_o;
    oe_seen = data_oe_o;
    rd_ni = 1'b1;
    repeat (5) @(negedge clk);
    cs_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // bit 4 strobes port A, bit 2 strobes port B
  task automatic strobe(input bit port_b, input logic [7:0] d);
    @(negedge clk);
    if (port_b) pb_i = d; else pa_i = d;
    if (port_b) pc_i[2] = 1'b0; else pc_i[4] = 1'b0;
    repeat (4) @(negedge clk);
    if (port_b) pc_i[2] = 1'b1; else pc_i[4] = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_rd0(input logic [1:0] a);
    case (a)
      2'd0:    return m_cw[4] ? pa_i : m_pa;
      2'd1:    return m_cw[1] ? pb_i : m_pb;
      default: return {m_cw[3] ? pc_i[7:4] : m_pc[7:4], m_cw[0] ? pc_i[3:0] : m_pc[3:0]};
    endcase
  endfunction

  function automatic logic [7:0] exp_pc_oe0(input logic [7:0] cw);
    return {{4{~cw[3]}}, {4{~cw[0]}}};
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 pa_oe", pa_oe_o, 8'h00);
    chk("R1 pb_oe", pb_oe_o, 8'h00);
    chk("R1 pc_oe", pc_oe_o, 8'h00);
    chk("R1 pins", {pa_o, pb_o, pc_o}, 24'h0);
    chk("R1 flags", {ovr_a_o, ovr_b_o, data_oe_o}, 3'b000);

    // R2 all outputs, basic mode
    host_write(2'd3, 8'h80);
    chk("R12 no drive on write", oe_seen, 1'b0);
    host_write(2'd0, 8'h5A);
    host_write(2'd1, 8'hC3);
    host_write(2'd2, 8'hF0);
    chk("R2 pa pins", {pa_o, pa_oe_o}, 16'h5AFF);
    chk("R2 pb pins", {pb_o, pb_oe_o}, 16'hC3FF);
    chk("R2 pc pins", {pc_o, pc_oe_o}, 16'hF0FF);
    host_read(2'd0, rv);
    chk("R5 readback A", rv, 8'h5A);
    chk("R12 drive on read", oe_seen, 1'b1);
    host_read(2'd1, rv);
    chk("R5 readback B", rv, 8'hC3);

    // R4 word without bit 7 ignored
    host_write(2'd3, 8'h1B);
    chk("R4 pa kept", {pa_o, pa_oe_o}, 16'h5AFF);
    chk("R4 pc kept", {pc_o, pc_oe_o}, 16'hF0FF);

    // R3 identical word clears latches
    host_write(2'd3, 8'h80);
    chk("R3 pa cleared", pa_o, 8'h00);
    chk("R3 pb cleared", pb_o, 8'h00);
    chk("R3 pc cleared", pc_o, 8'h00);

    // R6 port C split directions: upper in, lower out
    host_write(2'd3, 8'h88);
    host_write(2'd2, 8'hA5);
    pc_i = 8'h3C;
    chk("R6 pc oe", pc_oe_o, 8'h0F);
    host_read(2'd2, rv);
    chk("R6 pc mixed read", rv, 8'h35);

    // random basic-mode patterns
    for (int it = 0; it < 40; it++) begin
      m_cw = {1'b1, 2'b00, 1'($urandom), 1'($urandom), 1'b0, 1'($urandom), 1'($urandom)};
      host_write(2'd3, m_cw);
      m_pa = 8'($urandom); m_pb = 8'($urandom); m_pc = 8'($urandom);
      host_write(2'd0, m_pa);
      host_write(2'd1, m_pb);
      host_write(2'd2, m_pc);
      pa_i = 8'($urandom); pb_i = 8'($urandom); pc_i = 8'($urandom);
      chk("R2 rand pa_oe", pa_oe_o, m_cw[4] ? 8'h00 : 8'hFF);
      chk("R2 rand pb_oe", pb_oe_o, m_cw[1] ? 8'h00 : 8'hFF);
      chk("R6 rand pc_oe", pc_oe_o, exp_pc_oe0(m_cw));
      host_read(2'd0, rv);
      chk("R5 rand read A", rv, exp_rd0(2'd0));
      host_read(2'd1, rv);
      chk("R5 rand read B", rv, exp_rd0(2'd1));
      host_read(2'd2, rv);
      chk("R6 rand read C", rv, exp_rd0(2'd2));
    end

    // R7 strobed input on both groups: C upper out, C lower out
    pc_i = 8'hFF;
    repeat (4) @(negedge clk);
    host_write(2'd3, 8'hB6);
    chk("R7 pa forced input", pa_oe_o, 8'h00);
    chk("R7 pc handshake dirs", pc_oe_o, 8'hEB);
    strobe(1'b0, 8'h77);
    chk("R7 ibf A set", pc_o[5], 1'b1);
    host_read(2'd2, rv);
    chk("R9 pc status", rv, 8'h34);
    host_read(2'd0, rv);
    chk("R8 captured A", rv, 8'h77);
    chk("R8 ibf A cleared", pc_o[5], 1'b0);

    // R10 overrun
    strobe(1'b0, 8'h11);
    strobe(1'b0, 8'h22);
    chk("R10 overrun A", ovr_a_o, 1'b1);
    chk("R10 no overrun B", ovr_b_o, 1'b0);
    host_read(2'd0, rv);
    chk("R10 latest byte", rv, 8'h22);
    chk("R10 sticky after read", ovr_a_o, 1'b1);

    // R11 strobe B low across configuration
    @(negedge clk);
    pc_i[2] = 1'b0;
    repeat (4) @(negedge clk);
    host_write(2'd3, 8'hB6);
    chk("R3 overrun cleared", ovr_a_o, 1'b0);
    pb_i = 8'h44;
    pc_i[2] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11 no capture on first edge", pc_o[1], 1'b0);
    host_read(2'd1, rv);
    chk("R11 nothing captured", rv, 8'h00);
    strobe(1'b1, 8'h99);
    chk("R11 later capture ibf", pc_o[1], 1'b1);
    host_read(2'd1, rv);
    chk("R11 later capture data", rv, 8'h99);
    chk("R8 ibf B cleared", pc_o[1], 1'b0);

    finish_run();
  end
endmodule